// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This engine watches the byte stream that passes on a NAND flash data bus. It computes a Hamming code that corrects one bit and detects two bits over each fixed-size block of page data. A page is handled as up to `MAX_BLKS` consecutive blocks of `BLK_BYTES` bytes, and every block keeps its own code value.

When a page is written, the controller reads the finished codes back byte by byte through a spare-area selector and writes them after the data. When a page is read, the controller reads the stored code bytes out of the spare area and presents them one block at a time. The engine forms the syndrome and records a per-block result: clean, data bit correctable (with the failing byte and bit), check bit flipped, or uncorrectable.

Calculation runs only when an access starts on a block boundary. The starting block slot is taken from the start address, and each start clears all earlier per-block results.

Top module: `nand_hecc`

## Requirements
- R1: A start pulse whose address has all `log2(BLK_BYTES)` low bits zero arms the engine. A start at any other address leaves it disarmed, so that access produces no code.
- R2: Every start clears all code-valid and status-valid flags. It restarts the byte count at zero and sets the current block slot to the start address bits above the in-block offset.
- R3: Each byte has a position index `{byte offset, bit number}`. For each bit k of that index, code bit 2k+1 is the XOR of all data bits whose index has bit k set, and code bit 2k is the XOR of all data bits whose index has bit k clear.
- R4: A block closes when its `BLK_BYTES`-th accepted byte arrives. Its code and its code-valid flag appear after that same clock edge, and the slot then advances by one. Between starts, a valid code never changes and a flag never drops.
- R5: After the block in slot `MAX_BLKS-1` closes, the engine disarms. Bytes presented while disarmed, or with `byte_vld_i` low, change no state.
- R6: `spare_byte_o` for selector value s gives byte s mod 3 (least significant first, zero-padded above the code) of the code in slot s div 3. Selector values past the last slot give zero.
- R7: A check strobe for a slot whose code is valid sets that slot's status-valid flag and status after the edge. A check for a slot without a valid code is ignored.
- R8: A syndrome (stored XOR computed) of zero gives status 2'b00.
- R9: A syndrome in which every bit pair (2k+1, 2k) differs gives status 2'b01. The error position equals the odd syndrome bits, so the byte is position[high] and the bit is position[2:0].
- R10: A syndrome with exactly one bit set gives status 2'b10 (flipped check bit, data intact).
- R11: Any other syndrome, including every double-bit data error, gives status 2'b11.
- R12: A slot's error position output is zero whenever its status is not 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Access start pulse |
| start_addr_i | input | log2(BLK_BYTES*MAX_BLKS) | Column address of the access |
| byte_vld_i | input | 1 | Data byte present on the bus |
| byte_i | input | 8 | Data byte |
| chk_vld_i | input | 1 | Stored code presented for checking |
| chk_blk_i | input | log2(MAX_BLKS) | Slot being checked |
| chk_code_i | input | 2*(log2(BLK_BYTES)+3) | Stored code read from the spare area |
| spare_sel_i | input | log2(3*MAX_BLKS) rounded up | Spare byte selector |
| spare_byte_o | output | 8 | Selected spare-area code byte |
| code_o | output | MAX_BLKS*CW | Per-slot codes, slot 0 in the low bits |
| code_vld_o | output | MAX_BLKS | Per-slot code valid |
| stat_o | output | 2*MAX_BLKS | Per-slot check status |
| stat_vld_o | output | MAX_BLKS | Per-slot status valid |
| err_pos_o | output | MAX_BLKS*(log2(BLK_BYTES)+3) | Per-slot failing bit position |

## Verification
The bench builds the engine with `BLK_BYTES=128` and `MAX_BLKS=4`. The code is then 20 bits wide, so the spare layout carries four pad bits, and each full page takes only 512 bytes. Both extremes of the position range, bit 0 of byte 0 and bit 7 of byte 127, can be injected and checked in a short run. The smaller block also allows unaligned starts, mid-page starts in slot 2, restarts part-way through a block and overrun bytes after the last slot, all within a few thousand cycles.

// File: rtl/nand_hecc_pkg.sv
package nand_hecc_pkg;

   typedef enum logic [1:0] {
      ST_CLEAN    = 2'b00,
      ST_DATA_FIX = 2'b01,
      ST_CODE_FIX = 2'b10,
      ST_FAIL     = 2'b11
   } hecc_stat_e;

endpackage

// File: rtl/hecc_accum.sv
module hecc_accum #(
   parameter int BLK_BYTES = 512,
   parameter int MAX_BLKS  = 4
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         start_i,
   input  logic [$clog2(BLK_BYTES*MAX_BLKS)-1:0]        start_addr_i,
   input  logic                                         byte_vld_i,
   input  logic [7:0]                                   byte_i,
   output logic                                         armed_o,
   output logic                                         done_o,
   output logic [$clog2(MAX_BLKS)-1:0]                  done_idx_o,
   output logic [2*($clog2(BLK_BYTES)+3)-1:0]           code_o
);
   localparam int AW    = $clog2(BLK_BYTES);
   localparam int BW    = $clog2(MAX_BLKS);
   localparam int COL_W = AW + BW;
   localparam int HALF  = AW + 3;
   localparam int CW    = 2 * HALF;

   logic          armed_q;
   logic [AW-1:0] cnt_q;
   logic [BW-1:0] blk_q;
   logic [CW-1:0] acc_q;
   logic [CW-1:0] contrib;
   logic          bpar;
   logic          take;
   logic          last;

   always_comb begin
      bpar    = ^byte_i;
      contrib = '0;
      for (int j = 0; j < 8; j++) begin
         for (int k = 0; k < 3; k++) begin
            if (((j >> k) & 1) != 0) contrib[2*k+1] = contrib[2*k+1] ^ byte_i[j];
            else                     contrib[2*k]   = contrib[2*k]   ^ byte_i[j];
         end
      end
      for (int k = 0; k < AW; k++) begin
         if (cnt_q[k]) contrib[2*(k+3)+1] = bpar;
         else          contrib[2*(k+3)]   = bpar;
      end
   end

   assign take       = armed_q & byte_vld_i;
   assign last       = take & (&cnt_q);
   assign done_o     = last;
   assign done_idx_o = blk_q;
   assign code_o     = acc_q ^ contrib;
   assign armed_o    = armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         blk_q   <= '0;
         acc_q   <= '0;
      end else if (start_i) begin
         armed_q <= (start_addr_i[AW-1:0] == '0);
         cnt_q   <= '0;
         blk_q   <= start_addr_i[COL_W-1:AW];
         acc_q   <= '0;
      end else if (take) begin
         if (last) begin
            acc_q <= '0;
            cnt_q <= '0;
            blk_q <= blk_q + 1'b1;
            if (blk_q == BW'(MAX_BLKS - 1)) armed_q <= 1'b0;
         end else begin
            acc_q <= code_o;
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
   import nand_hecc_pkg::*;
#(
   parameter int HALF = 12
) (
   input  logic [2*HALF-1:0] stored_i,
   input  logic [2*HALF-1:0] calc_i,
   output hecc_stat_e        stat_o,
   output logic [HALF-1:0]   pos_o
);
   logic [2*HALF-1:0] syn;
   logic [HALF-1:0]   odd_b;
   logic [HALF-1:0]   even_b;

   assign syn = stored_i ^ calc_i;

   for (genvar k = 0; k < HALF; k++) begin : g_pair
      assign odd_b[k]  = syn[2*k+1];
      assign even_b[k] = syn[2*k];
   end

   always_comb begin
      pos_o = '0;
      if (syn == '0) begin
         stat_o = ST_CLEAN;
      end else if (&(odd_b ^ even_b)) begin
         stat_o = ST_DATA_FIX;
         pos_o  = odd_b;
      end else if ($countones(syn) == 1) begin
         stat_o = ST_CODE_FIX;
      end else begin
         stat_o = ST_FAIL;
      end
   end
endmodule

// File: rtl/hecc_bank.sv
module hecc_bank #(
   parameter int MAX_BLKS = 4,
   parameter int HALF     = 12
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start_i,
   input  logic                           done_i,
   input  logic [$clog2(MAX_BLKS)-1:0]    done_idx_i,
   input  logic [2*HALF-1:0]              done_code_i,
   input  logic                           chk_vld_i,
   input  logic [$clog2(MAX_BLKS)-1:0]    chk_blk_i,
   input  logic [1:0]                     cls_stat_i,
   input  logic [HALF-1:0]                cls_pos_i,
   output logic [MAX_BLKS*2*HALF-1:0]     code_o,
   output logic [MAX_BLKS-1:0]            code_vld_o,
   output logic [2*MAX_BLKS-1:0]          stat_o,
   output logic [MAX_BLKS-1:0]            stat_vld_o,
   output logic [MAX_BLKS*HALF-1:0]       pos_o
);
   localparam int BW = $clog2(MAX_BLKS);
   localparam int CW = 2 * HALF;

   for (genvar i = 0; i < MAX_BLKS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_o[i*CW +: CW]     <= '0;
            code_vld_o[i]          <= 1'b0;
            stat_o[2*i +: 2]       <= '0;
            stat_vld_o[i]          <= 1'b0;
            pos_o[i*HALF +: HALF]  <= '0;
         end else if (start_i) begin
            code_vld_o[i]          <= 1'b0;
            stat_vld_o[i]          <= 1'b0;
            stat_o[2*i +: 2]       <= '0;
            pos_o[i*HALF +: HALF]  <= '0;
         end else begin
            if (done_i && done_idx_i == BW'(i)) begin
               code_o[i*CW +: CW] <= done_code_i;
               code_vld_o[i]      <= 1'b1;
            end
            if (chk_vld_i && chk_blk_i == BW'(i) && code_vld_o[i]) begin
               stat_o[2*i +: 2]      <= cls_stat_i;
               pos_o[i*HALF +: HALF] <= cls_pos_i;
               stat_vld_o[i]         <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/nand_hecc.sv
module nand_hecc
   import nand_hecc_pkg::*;
#(
   parameter int BLK_BYTES = 512,
   parameter int MAX_BLKS  = 4,
   localparam int AW       = $clog2(BLK_BYTES),
   localparam int BW       = $clog2(MAX_BLKS),
   localparam int COL_W    = AW + BW,
   localparam int HALF     = AW + 3,
   localparam int CW       = 2 * HALF,
   localparam int CB       = (CW + 7) / 8,
   localparam int SW       = $clog2(CB * MAX_BLKS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [COL_W-1:0]         start_addr_i,
   input  logic                     byte_vld_i,
   input  logic [7:0]               byte_i,
   input  logic                     chk_vld_i,
   input  logic [BW-1:0]            chk_blk_i,
   input  logic [CW-1:0]            chk_code_i,
   input  logic [SW-1:0]            spare_sel_i,
   output logic [7:0]               spare_byte_o,
   output logic [MAX_BLKS*CW-1:0]   code_o,
   output logic [MAX_BLKS-1:0]      code_vld_o,
   output logic [2*MAX_BLKS-1:0]    stat_o,
   output logic [MAX_BLKS-1:0]      stat_vld_o,
   output logic [MAX_BLKS*HALF-1:0] err_pos_o
);
   if (BLK_BYTES < 8 || (1 << AW) != BLK_BYTES) begin : g_bad_blk
      $error("nand_hecc: BLK_BYTES must be a power of two of at least 8");
   end
   if (MAX_BLKS < 2 || (1 << BW) != MAX_BLKS) begin : g_bad_cnt
      $error("nand_hecc: MAX_BLKS must be a power of two of at least 2");
   end

   logic             armed;
   logic             done;
   logic [BW-1:0]    done_idx;
   logic [CW-1:0]    done_code;
   logic [CW-1:0]    sel_code;
   hecc_stat_e       cls_stat;
   logic [HALF-1:0]  cls_pos;
   logic [MAX_BLKS*CB*8-1:0] spare_flat;

   hecc_accum #(.BLK_BYTES(BLK_BYTES), .MAX_BLKS(MAX_BLKS)) u_accum (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .start_addr_i (start_addr_i),
      .byte_vld_i   (byte_vld_i),
      .byte_i       (byte_i),
      .armed_o      (armed),
      .done_o       (done),
      .done_idx_o   (done_idx),
      .code_o       (done_code)
   );

   assign sel_code = code_o[chk_blk_i*CW +: CW];

   hecc_classify #(.HALF(HALF)) u_cls (
      .stored_i (chk_code_i),
      .calc_i   (sel_code),
      .stat_o   (cls_stat),
      .pos_o    (cls_pos)
   );

   hecc_bank #(.MAX_BLKS(MAX_BLKS), .HALF(HALF)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .done_i      (done),
      .done_idx_i  (done_idx),
      .done_code_i (done_code),
      .chk_vld_i   (chk_vld_i),
      .chk_blk_i   (chk_blk_i),
      .cls_stat_i  (cls_stat),
      .cls_pos_i   (cls_pos),
      .code_o      (code_o),
      .code_vld_o  (code_vld_o),
      .stat_o      (stat_o),
      .stat_vld_o  (stat_vld_o),
      .pos_o       (err_pos_o)
   );

   for (genvar i = 0; i < MAX_BLKS; i++) begin : g_spare
      if (CB * 8 > CW) begin : g_pad
         assign spare_flat[i*CB*8 +: CB*8] = {{(CB*8-CW){1'b0}}, code_o[i*CW +: CW]};
      end else begin : g_nopad
         assign spare_flat[i*CB*8 +: CB*8] = code_o[i*CW +: CW];
      end
   end

   always_comb begin
      spare_byte_o = '0;
      if (int'(spare_sel_i) < CB * MAX_BLKS) spare_byte_o = spare_flat[spare_sel_i*8 +: 8];
   end
endmodule

// File: rtl/nand_hecc_chk.sv
module nand_hecc_chk #(
   parameter int BLK_BYTES = 512,
   parameter int MAX_BLKS  = 4,
   localparam int AW       = $clog2(BLK_BYTES),
   localparam int COL_W    = AW + $clog2(MAX_BLKS),
   localparam int HALF     = AW + 3,
   localparam int CW       = 2 * HALF
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start_i,
   input logic [COL_W-1:0]         start_addr_i,
   input logic                     armed,
   input logic [MAX_BLKS*CW-1:0]   code_o,
   input logic [MAX_BLKS-1:0]      code_vld_o,
   input logic [2*MAX_BLKS-1:0]    stat_o,
   input logic [MAX_BLKS-1:0]      stat_vld_o,
   input logic [MAX_BLKS*HALF-1:0] err_pos_o
);
   p_arm_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && start_addr_i[AW-1:0] == '0 |=> armed);

   p_no_arm_unaligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && start_addr_i[AW-1:0] != '0 |=> !armed);

   p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (code_vld_o == '0 && stat_vld_o == '0));

   p_flags_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ((code_vld_o & $past(code_vld_o)) == $past(code_vld_o)));

   p_one_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $countones(code_vld_o & ~$past(code_vld_o)) <= 1);

   p_disarm_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(code_vld_o[MAX_BLKS-1]) |-> !armed);

   p_stat_needs_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_vld_o & ~code_vld_o) == '0);

   for (genvar i = 0; i < MAX_BLKS; i++) begin : g_slot
      p_code_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
         code_vld_o[i] && !start_i |=> $stable(code_o[i*CW +: CW]));

      p_pos_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
         stat_o[2*i +: 2] != 2'b01 |-> err_pos_o[i*HALF +: HALF] == '0);
   end
endmodule

bind nand_hecc nand_hecc_chk #(.BLK_BYTES(BLK_BYTES), .MAX_BLKS(MAX_BLKS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .start_addr_i (start_addr_i),
   .armed        (armed),
   .code_o       (code_o),
   .code_vld_o   (code_vld_o),
   .stat_o       (stat_o),
   .stat_vld_o   (stat_vld_o),
   .err_pos_o    (err_pos_o)
);

// File: tb/nand_hecc_tb.sv
module nand_hecc_tb;
   localparam int CLK_PERIOD = 10;
   localparam int BLK   = 128;
   localparam int MAXB  = 4;
   localparam int AW    = $clog2(BLK);
   localparam int BW    = $clog2(MAXB);
   localparam int COL_W = AW + BW;
   localparam int HALF  = AW + 3;
   localparam int CW    = 2 * HALF;
   localparam int CB    = (CW + 7) / 8;
   localparam int SW    = $clog2(CB * MAXB);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [COL_W-1:0] start_addr = '0;
   logic byte_vld = 1'b0;
   logic [7:0] byte_d = '0;
   logic chk_vld = 1'b0;
   logic [BW-1:0] chk_blk = '0;
   logic [CW-1:0] chk_code = '0;
   logic [SW-1:0] spare_sel = '0;
   logic [7:0] spare_byte;
   logic [MAXB*CW-1:0] code_o;
   logic [MAXB-1:0] code_vld;
   logic [2*MAXB-1:0] stat_o;
   logic [MAXB-1:0] stat_vld;
   logic [MAXB*HALF-1:0] err_pos;

   int total = 0;
   int bad = 0;
   bit cmp_on = 1'b0;
   bit finished = 1'b0;

   bit m_armed = 1'b0;
   int m_blk = 0;
   logic [7:0] cur[$];
   logic [CW-1:0] m_code[MAXB];
   logic [MAXB-1:0] m_cvld = '0;
   logic [MAXB-1:0] m_svld = '0;
   logic [1:0] m_stat[MAXB];
   logic [HALF-1:0] m_pos[MAXB];
   logic [7:0] pg[MAXB][BLK];

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_hecc #(.BLK_BYTES(BLK), .MAX_BLKS(MAXB)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
      .byte_vld_i(byte_vld), .byte_i(byte_d), .chk_vld_i(chk_vld),
      .chk_blk_i(chk_blk), .chk_code_i(chk_code), .spare_sel_i(spare_sel),
      .spare_byte_o(spare_byte), .code_o(code_o), .code_vld_o(code_vld),
      .stat_o(stat_o), .stat_vld_o(stat_vld), .err_pos_o(err_pos)
   );

   function automatic logic [CW-1:0] ref_code(input logic [7:0] q[$]);
      logic [CW-1:0] c = '0;
      for (int i = 0; i < q.size(); i++)
         for (int b = 0; b < 8; b++)
            if (q[i][b]) begin
               int p = i * 8 + b;
               for (int k = 0; k < HALF; k++)
                  if (((p >> k) & 1) != 0) c[2*k+1] = ~c[2*k+1];
                  else c[2*k] = ~c[2*k];
            end
      return c;
   endfunction

   task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: got %h exp %h", req, what, got, exp);
      end
   endtask

   function automatic string stat_req(input logic [1:0] s);
      case (s)
         2'b00: return "R8";
         2'b01: return "R9";
         2'b10: return "R10";
         default: return "R11";
      endcase
   endfunction

   // Reference model compared on every clock
   always @(negedge clk) begin
      if (cmp_on) begin
         check("R4", "code_vld", 64'(code_vld), 64'(m_cvld));
         check("R7", "stat_vld", 64'(stat_vld), 64'(m_svld));
         for (int i = 0; i < MAXB; i++) begin
            if (m_cvld[i]) check("R3", $sformatf("code slot%0d", i), 64'(code_o[i*CW +: CW]), 64'(m_code[i]));
            if (m_svld[i]) begin
               check(stat_req(m_stat[i]), $sformatf("stat slot%0d", i), 64'(stat_o[2*i +: 2]), 64'(m_stat[i]));
               check(m_stat[i] == 2'b01 ? "R9" : "R12", $sformatf("pos slot%0d", i),
                     64'(err_pos[i*HALF +: HALF]), 64'(m_pos[i]));
            end
         end
      end
   end

   task automatic do_start(input int addr);
      @(negedge clk);
      start = 1'b1;
      start_addr = COL_W'(addr);
      @(posedge clk);
      #1;
      start = 1'b0;
      m_cvld = '0;
      m_svld = '0;
      for (int i = 0; i < MAXB; i++) begin m_stat[i] = '0; m_pos[i] = '0; end
      cur.delete();
      m_armed = (addr % BLK) == 0;
      m_blk = (addr / BLK) % MAXB;
   endtask

   task automatic drive_byte(input logic [7:0] b);
      @(negedge clk);
      byte_vld = 1'b1;
      byte_d = b;
      @(posedge clk);
      #1;
      byte_vld = 1'b0;
      if (m_armed) begin
         cur.push_back(b);
         if (cur.size() == BLK) begin
            m_code[m_blk] = ref_code(cur);
            m_cvld[m_blk] = 1'b1;
            cur.delete();
            if (m_blk == MAXB - 1) m_armed = 1'b0;
            m_blk = (m_blk + 1) % MAXB;
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         byte_d = 8'hA5;
      end
   endtask

   task automatic send_block(input int b);
      for (int i = 0; i < BLK; i++) begin
         drive_byte(pg[b][i]);
         if (i == 40) idle(2);
      end
   endtask

   task automatic do_check(input int b, input logic [CW-1:0] stored, input logic [1:0] es, input logic [HALF-1:0] ep);
      @(negedge clk);
      chk_vld = 1'b1;
      chk_blk = BW'(b);
      chk_code = stored;
      @(posedge clk);
      #1;
      chk_vld = 1'b0;
      if (m_cvld[b]) begin
         m_svld[b] = 1'b1;
         m_stat[b] = es;
         m_pos[b] = ep;
      end
   endtask

   function automatic logic [CW-1:0] flipped_code(input int b, input int p1, input int p2);
      logic [7:0] q[$];
      for (int i = 0; i < BLK; i++) q.push_back(pg[b][i]);
      if (p1 >= 0) q[p1/8][p1%8] = ~q[p1/8][p1%8];
      if (p2 >= 0) q[p2/8][p2%8] = ~q[p2/8][p2%8];
      return ref_code(q);
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] lf = 8'h5B;
      for (int i = 0; i < BLK; i++) begin
         pg[0][i] = 8'h00;
         pg[1][i] = 8'hFF;
         pg[2][i] = 8'(i * 3);
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         pg[3][i] = lf;
      end
      for (int i = 0; i < MAXB; i++) begin m_code[i] = '0; m_stat[i] = '0; m_pos[i] = '0; end

      repeat (3) @(posedge clk);
      #1;
      check("R4", "reset code_vld", 64'(code_vld), 64'd0);
      check("R7", "reset stat_vld", 64'(stat_vld), 64'd0);
      rst_n = 1'b1;
      cmp_on = 1'b1;

      // Full page from slot 0 with mixed patterns
      do_start(0);
      check("R2", "flags after start", 64'(code_vld | stat_vld), 64'd0);
      for (int b = 0; b < MAXB; b++) send_block(b);
      for (int i = 0; i < 10; i++) drive_byte(8'h3C);
      check("R5", "flags after overrun", 64'(code_vld), 64'hF);
      check("R5", "slot0 after overrun", 64'(code_o[0 +: CW]), 64'(m_code[0]));

      // Spare-area byte order
      for (int s = 0; s < (1 << SW); s++) begin
         logic [7:0] e;
         logic [CB*8-1:0] wide;
         @(negedge clk);
         spare_sel = SW'(s);
         #1;
         if (s < CB * MAXB) begin
            wide = (CB*8)'(m_code[s / CB]);
            e = wide[(s % CB)*8 +: 8];
         end else e = 8'h00;
         check("R6", $sformatf("spare sel%0d", s), 64'(spare_byte), 64'(e));
      end

      // Checks of each result kind
      do_check(0, m_code[0], 2'b00, '0);
      do_check(1, flipped_code(1, 77*8+5, -1), 2'b01, HALF'(77*8+5));
      do_check(2, m_code[2] ^ CW'(1 << 7), 2'b10, '0);
      do_check(3, flipped_code(3, 0, BLK*8-1), 2'b11, '0);
      check("R11", "slot3 double flip", 64'(stat_o[6 +: 2]), 64'd3);
      check("R9", "slot1 position", 64'(err_pos[HALF +: HALF]), 64'(77*8+5));

      // Second page: extreme positions, after a restart
      do_start(0);
      check("R2", "flags cleared", 64'(code_vld | stat_vld), 64'd0);
      send_block(2);
      send_block(3);
      do_check(0, flipped_code(2, 0, -1), 2'b01, '0);
      do_check(1, flipped_code(3, BLK*8-1, -1), 2'b01, HALF'(BLK*8-1));

      // Unaligned start yields nothing
      do_start(5);
      send_block(1);
      check("R1", "unaligned code_vld", 64'(code_vld), 64'd0);

      // Start in slot 2; check of an empty slot is ignored
      do_start(2 * BLK);
      send_block(3);
      send_block(0);
      for (int i = 0; i < 4; i++) drive_byte(8'h11);
      check("R2", "slots from address", 64'(code_vld), 64'hC);
      do_check(0, '0, 2'b00, '0);
      check("R7", "check on empty slot", 64'(stat_vld), 64'd0);
      do_check(2, flipped_code(3, 9, 300), 2'b11, '0);

      // Restart part-way through a block
      do_start(0);
      for (int i = 0; i < 50; i++) drive_byte(8'hE7);
      do_start(0);
      send_block(2);
      check("R2", "restart slot0", 64'(code_o[0 +: CW]), 64'(ref_code('{})) ^ 64'(m_code[0]) ^ 64'(ref_code('{})));
      idle(3);

      cmp_on = 1'b0;
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule